// File: doc/BRIEF.md
# Main/Side Road Traffic Signal Controller

This block runs the lamps at a crossing of a main road and a side road. The main road keeps green by default. The side road gets green only when a vehicle is waiting on it.

The controller steps through four phases in a fixed loop: main green, main yellow, side green, side yellow. It reads a one-second tick and one vehicle sensor for each road. It drives a red, a yellow and a green lamp for each road. It also drives a two-digit BCD countdown for each road.

A road's countdown depends on what that road is showing:
- While a road has green, its countdown shows the seconds left until its yellow.
- While the other road has green, its countdown shows the seconds left until it gets green again.
- While either road has yellow, both countdowns show the seconds left in that yellow.

Segment decoding, digit scanning and clock division are done outside the block.

Top module: `traffic_signal_ctrl`

## Requirements
- R1: A synchronous reset puts the block in main green with side red, and both countdowns read 8'h00 after the first clock edge that sees reset.
- R2: Each road lights exactly one lamp at all times. Whenever a road shows green or yellow, the other road shows red.
- R3: In main green, a tick with the side sensor inactive keeps main green, clears the phase timer, and drives both countdowns to 8'h00.
- R4: In main green, a tick with the side sensor active and the main sensor inactive moves the block to main yellow, with both countdowns at 8'h05.
- R5: In main green with both sensors active on every tick, main green lasts 45 ticks. After the k-th such tick, the main countdown reads 45−k and the side countdown reads 50−k. The 45th tick starts main yellow.
- R6: Each yellow phase lasts 5 ticks. Both countdowns read 5 on entry and fall by one per tick.
- R7: On entry to side green, the side countdown reads 25 and the main countdown reads 30. With both sensors active, side green lasts 25 ticks and then goes to side yellow.
- R8: In side green, a tick with the side sensor inactive moves the block to side yellow.
- R9: In side green with only the side sensor active, the side countdown falls to 0 and stays there, while the main countdown stays at 5. The first tick that also sees the main sensor then moves the block to side yellow.
- R10: On a clock edge with the tick input low, the lamps and countdowns do not change.
- R11: Each countdown is packed BCD: bits 7:4 hold the tens digit and bits 3:0 hold the units digit.
- R12: Phases occur only in the order main green, main yellow, side green, side yellow, then main green again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse once per second |
| main_car | input | 1 | Vehicle present on the main road |
| side_car | input | 1 | Vehicle present on the side road |
| main_red | output | 1 | Main road red lamp |
| main_yellow | output | 1 | Main road yellow lamp |
| main_green | output | 1 | Main road green lamp |
| side_red | output | 1 | Side road red lamp |
| side_yellow | output | 1 | Side road yellow lamp |
| side_green | output | 1 | Side road green lamp |
| main_count | output | 8 | Main road countdown, packed BCD |
| side_count | output | 8 | Side road countdown, packed BCD |

## Verification
The hardest state to reach is a held side green with its countdown stuck at zero (R9). The stimulus gets there in three steps:
- A side-only demand ends main green at once.
- The side sensor is then held active with the main sensor inactive for more than 25 ticks.
- A main-road vehicle is then added, so the release into side yellow happens from the frozen count.

The bench also interrupts a timed main green by dropping the side demand part way through. This shows that the timer restarts from untimed, not from where it stopped.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_WARN = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_e;

    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } lamp_t;

    localparam int unsigned ROADS = 2;

    // Two-digit packed BCD; values above 99 saturate.
    function automatic logic [7:0] to_bcd2(input int unsigned v);
        int unsigned c;
        c = (v > 99) ? 99 : v;
        return {4'(c / 10), 4'(c % 10)};
    endfunction

    function automatic phase_e go_of_road(input int unsigned road);
        return (road == 0) ? PH_MAIN_GO : PH_SIDE_GO;
    endfunction

endpackage

// File: rtl/tsig_phase_fsm.sv
module tsig_phase_fsm
    import tsig_pkg::*;
#(
    parameter int unsigned MAIN_S = 45,
    parameter int unsigned SIDE_S = 25,
    parameter int unsigned YEL_S  = 5,
    parameter int unsigned TW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          main_car,
    input  logic          side_car,
    output phase_e        phase_d,
    output logic [TW-1:0] rem_d,
    output logic          timed_d
);

    localparam logic [TW-1:0] MAIN_LOAD = TW'(MAIN_S - 1);
    localparam logic [TW-1:0] SIDE_LOAD = TW'(SIDE_S);
    localparam logic [TW-1:0] YEL_LOAD  = TW'(YEL_S);
    localparam logic [TW-1:0] ONE       = TW'(1);

    phase_e        phase_q;
    logic [TW-1:0] rem_q;
    logic          timed_q;
    logic          last_second;

    assign last_second = (rem_q <= ONE);

    always_comb begin
        phase_d = phase_q;
        rem_d   = rem_q;
        timed_d = timed_q;
        if (tick) begin
            unique case (phase_q)
                PH_MAIN_GO: begin
                    if (!side_car) begin
                        rem_d   = '0;
                        timed_d = 1'b0;
                    end else if (!main_car) begin
                        phase_d = PH_MAIN_WARN;
                        rem_d   = YEL_LOAD;
                        timed_d = 1'b1;
                    end else if (!timed_q) begin
                        rem_d   = MAIN_LOAD;
                        timed_d = 1'b1;
                    end else if (last_second) begin
                        phase_d = PH_MAIN_WARN;
                        rem_d   = YEL_LOAD;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
                PH_MAIN_WARN: begin
                    if (last_second) begin
                        phase_d = PH_SIDE_GO;
                        rem_d   = SIDE_LOAD;
                        timed_d = 1'b1;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
                PH_SIDE_GO: begin
                    if (!side_car || (main_car && last_second)) begin
                        phase_d = PH_SIDE_WARN;
                        rem_d   = YEL_LOAD;
                    end else if (rem_q != '0) begin
                        rem_d = rem_q - ONE;
                    end
                end
                PH_SIDE_WARN: begin
                    if (last_second) begin
                        phase_d = PH_MAIN_GO;
                        rem_d   = '0;
                        timed_d = 1'b0;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
                default: begin
                    phase_d = PH_MAIN_GO;
                    rem_d   = '0;
                    timed_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_MAIN_GO;
            rem_q   <= '0;
            timed_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            rem_q   <= rem_d;
            timed_q <= timed_d;
        end
    end

endmodule

// File: rtl/tsig_road_out.sv
module tsig_road_out
    import tsig_pkg::*;
#(
    parameter phase_e      OWN_GO = PH_MAIN_GO,
    parameter int unsigned YEL_S  = 5,
    parameter int unsigned TW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase_d,
    input  logic [TW-1:0] rem_d,
    input  logic          timed_d,
    output lamp_t         lamp,
    output logic [7:0]    count
);

    localparam phase_e OWN_WARN = (OWN_GO == PH_MAIN_GO) ? PH_MAIN_WARN : PH_SIDE_WARN;
    localparam phase_e OTHER_GO = (OWN_GO == PH_MAIN_GO) ? PH_SIDE_GO : PH_MAIN_GO;
    localparam lamp_t  RST_LAMP = (OWN_GO == PH_MAIN_GO) ? lamp_t'(3'b001) : lamp_t'(3'b100);

    lamp_t       lamp_n;
    int unsigned secs_n;

    always_comb begin
        lamp_n = '0;
        if (phase_d == OWN_GO)        lamp_n.green  = 1'b1;
        else if (phase_d == OWN_WARN) lamp_n.yellow = 1'b1;
        else                          lamp_n.red    = 1'b1;

        if (!timed_d)                 secs_n = 0;
        else if (phase_d == OTHER_GO) secs_n = 32'(rem_d) + YEL_S;
        else                          secs_n = 32'(rem_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp  <= RST_LAMP;
            count <= 8'h00;
        end else begin
            lamp  <= lamp_n;
            count <= to_bcd2(secs_n);
        end
    end

endmodule

// File: rtl/traffic_signal_ctrl.sv
module traffic_signal_ctrl
    import tsig_pkg::*;
#(
    parameter int unsigned MAIN_S = 45,
    parameter int unsigned SIDE_S = 25,
    parameter int unsigned YEL_S  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       main_car,
    input  logic       side_car,
    output logic       main_red,
    output logic       main_yellow,
    output logic       main_green,
    output logic       side_red,
    output logic       side_yellow,
    output logic       side_green,
    output logic [7:0] main_count,
    output logic [7:0] side_count
);

    localparam int unsigned LONGEST = (MAIN_S > SIDE_S)
        ? ((MAIN_S > YEL_S) ? MAIN_S : YEL_S)
        : ((SIDE_S > YEL_S) ? SIDE_S : YEL_S);
    localparam int unsigned TW = $clog2(LONGEST + 1);

    phase_e        phase_d;
    logic [TW-1:0] rem_d;
    logic          timed_d;
    lamp_t         road_lamp  [ROADS];
    logic [7:0]    road_count [ROADS];

    tsig_phase_fsm #(
        .MAIN_S (MAIN_S),
        .SIDE_S (SIDE_S),
        .YEL_S  (YEL_S),
        .TW     (TW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .main_car (main_car),
        .side_car (side_car),
        .phase_d  (phase_d),
        .rem_d    (rem_d),
        .timed_d  (timed_d)
    );

    for (genvar r = 0; r < ROADS; r++) begin : g_road
        tsig_road_out #(
            .OWN_GO (go_of_road(r)),
            .YEL_S  (YEL_S),
            .TW     (TW)
        ) u_out (
            .clk     (clk),
            .rst     (rst),
            .phase_d (phase_d),
            .rem_d   (rem_d),
            .timed_d (timed_d),
            .lamp    (road_lamp[r]),
            .count   (road_count[r])
        );
    end

    assign main_red    = road_lamp[0].red;
    assign main_yellow = road_lamp[0].yellow;
    assign main_green  = road_lamp[0].green;
    assign side_red    = road_lamp[1].red;
    assign side_yellow = road_lamp[1].yellow;
    assign side_green  = road_lamp[1].green;
    assign main_count  = road_count[0];
    assign side_count  = road_count[1];

endmodule

// File: rtl/tsig_checker.sv
module tsig_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       main_car,
    input logic       side_car,
    input logic       main_red,
    input logic       main_yellow,
    input logic       main_green,
    input logic       side_red,
    input logic       side_yellow,
    input logic       side_green,
    input logic [7:0] main_count,
    input logic [7:0] side_count
);

    // R2: one lamp per road
    assert_one_lamp_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({main_red, main_yellow, main_green}) == 1 &&
        $countones({side_red, side_yellow, side_green}) == 1);

    // R2: the road not moving shows red
    assert_cross_red_R2: assert property (@(posedge clk) disable iff (rst)
        main_red || side_red);

    assert_untimed_hold_R3: assert property (@(posedge clk) disable iff (rst)
        tick && main_green && !side_car |=>
        main_green && main_count == 8'h00 && side_count == 8'h00);

    assert_early_exit_R4: assert property (@(posedge clk) disable iff (rst)
        tick && main_green && side_car && !main_car |=> main_yellow);

    assert_yellow_count_R6: assert property (@(posedge clk) disable iff (rst)
        (main_yellow || side_yellow) |-> main_count == side_count && main_count != 8'h00);

    assert_side_drop_R8: assert property (@(posedge clk) disable iff (rst)
        tick && side_green && !side_car |=> side_yellow);

    assert_no_tick_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({main_red, main_yellow, main_green, side_red,
                           side_yellow, side_green, main_count, side_count}));

    assert_order_side_go_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(side_green) |-> $past(main_yellow));

    assert_order_main_go_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(main_green) |-> $past(side_yellow));

    assert_order_main_warn_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(main_yellow) |-> $past(main_green));

endmodule

bind traffic_signal_ctrl tsig_checker u_tsig_checker (.*);

// File: tb/traffic_signal_ctrl_bench.sv
`timescale 1ns/1ps
module traffic_signal_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       main_car = 1'b0;
    logic       side_car = 1'b0;
    logic       main_red, main_yellow, main_green;
    logic       side_red, side_yellow, side_green;
    logic [7:0] main_count, side_count;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    localparam logic [7:0] L_MG = 8'b00_001_100;
    localparam logic [7:0] L_MY = 8'b00_010_100;
    localparam logic [7:0] L_SG = 8'b00_100_001;
    localparam logic [7:0] L_SY = 8'b00_100_010;

    traffic_signal_ctrl u_traffic_signal_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .main_car(main_car), .side_car(side_car),
        .main_red(main_red), .main_yellow(main_yellow), .main_green(main_green),
        .side_red(side_red), .side_yellow(side_yellow), .side_green(side_green),
        .main_count(main_count), .side_count(side_count)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] lamps();
        return {2'b00, main_red, main_yellow, main_green, side_red, side_yellow, side_green};
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model: phase number and seconds elapsed in the phase.
    // 0 main green, 1 main yellow, 2 side green, 3 side yellow.
    int ph  = 0;
    int sec = 0;

    always @(posedge clk) begin
        if (rst) begin
            ph  <= 0;
            sec <= 0;
        end else if (tick) begin
            case (ph)
                0: if (!side_car)                  sec <= 0;
                   else if (!main_car || sec + 1 >= 45) begin ph <= 1; sec <= 0; end
                   else                            sec <= sec + 1;
                1: if (sec + 1 >= 5) begin ph <= 2; sec <= 0; end else sec <= sec + 1;
                2: if (!side_car || (main_car && sec + 1 >= 25)) begin ph <= 3; sec <= 0; end
                   else if (sec < 25)              sec <= sec + 1;
                default: if (sec + 1 >= 5) begin ph <= 0; sec <= 0; end else sec <= sec + 1;
            endcase
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            logic [7:0] el;
            int em, es;
            case (ph)
                0: begin el = L_MG; em = (sec == 0) ? 0 : 45 - sec; es = (sec == 0) ? 0 : 50 - sec; end
                1: begin el = L_MY; em = 5 - sec;  es = 5 - sec;  end
                2: begin el = L_SG; em = 30 - sec; es = 25 - sec; end
                default: begin el = L_SY; em = 5 - sec; es = 5 - sec; end
            endcase
            check8("R12", "lamps vs model", lamps(), el);
            check8("R11", "main count vs model", main_count, bcd(em));
            check8("R11", "side count vs model", side_count, bcd(es));
            check8("R2", "one lamp per road and a red",
                   8'(($countones({main_red, main_yellow, main_green}) == 1) &&
                      ($countones({side_red, side_yellow, side_green}) == 1) &&
                      (main_red || side_red)), 8'd1);
        end
    end

    // Starts and ends at a falling edge, two cycles after the ticked edge.
    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_state(input string req, input logic [7:0] l,
                                input logic [7:0] m, input logic [7:0] s);
        check8(req, "lamps", lamps(), l);
        check8(req, "main_count", main_count, m);
        check8(req, "side_count", side_count, s);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_state("R1", L_MG, 8'h00, 8'h00);
        rst   = 1'b0;
        armed = 1'b1;

        do_ticks(10);
        expect_state("R3", L_MG, 8'h00, 8'h00);

        side_car = 1'b1;
        do_ticks(1);
        expect_state("R4", L_MY, 8'h05, 8'h05);
        do_ticks(1);
        expect_state("R6", L_MY, 8'h04, 8'h04);
        do_ticks(4);
        expect_state("R7", L_SG, 8'h30, 8'h25);

        do_ticks(30);
        expect_state("R9", L_SG, 8'h05, 8'h00);
        begin
            logic [7:0] snap_l, snap_m, snap_s;
            snap_l = lamps(); snap_m = main_count; snap_s = side_count;
            repeat (3) @(negedge clk);
            expect_state("R10", snap_l, snap_m, snap_s);
        end
        main_car = 1'b1;
        do_ticks(1);
        expect_state("R9", L_SY, 8'h05, 8'h05);

        do_ticks(5);
        expect_state("R12", L_MG, 8'h00, 8'h00);
        do_ticks(1);
        expect_state("R11", L_MG, 8'h44, 8'h49);
        do_ticks(43);
        expect_state("R5", L_MG, 8'h01, 8'h06);
        do_ticks(1);
        expect_state("R5", L_MY, 8'h05, 8'h05);

        do_ticks(5);
        expect_state("R7", L_SG, 8'h30, 8'h25);
        do_ticks(24);
        expect_state("R7", L_SG, 8'h06, 8'h01);
        do_ticks(1);
        expect_state("R7", L_SY, 8'h05, 8'h05);
        do_ticks(5);
        expect_state("R12", L_MG, 8'h00, 8'h00);

        do_ticks(3);
        expect_state("R5", L_MG, 8'h42, 8'h47);
        side_car = 1'b0;
        do_ticks(1);
        expect_state("R3", L_MG, 8'h00, 8'h00);

        side_car = 1'b1;
        main_car = 1'b0;
        do_ticks(6);
        expect_state("R12", L_SG, 8'h30, 8'h25);
        side_car = 1'b0;
        do_ticks(1);
        expect_state("R8", L_SY, 8'h05, 8'h05);
        do_ticks(5);
        expect_state("R12", L_MG, 8'h00, 8'h00);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule